// File: doc/BRIEF.md
# Asynchronous static memory controller

This block converts single read and write requests, presented on a valid/ready handshake, into asynchronous cycles on an external SRAM, pseudo-static RAM or NOR flash. It drives a 26-bit address, a 16-bit bidirectional data bus, one active-low chip select per bank, an output enable, a write enable and two active-low byte-lane enables. Every pin is produced from state registers clocked by the system clock. The clock itself never reaches the memory.

Each bank has a set of configuration inputs: memory type, extended-mode enable, a read timing mode, a write timing mode, an address-setup length and a data-phase length. With extended mode off, the memory type picks the timing. With extended mode on, reads and writes each take their own mode out of four: A, B, C and D. Read data is captured on the last data-phase clock, while chip select is still low. It is returned one clock later as a single-cycle response. At least one clock with every chip select high separates consecutive transactions.

Top module: `asmc_top`

## Requirements
- R1: After reset, `req_ready_o` is 1, every chip select, `mem_oe_n_o`, `mem_we_n_o` and both byte-lane enables are high, and `rsp_valid_o` is 0. `req_ready_o` is high only while the controller is idle. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low in the next cycle.
- R2: With the bank's extended bit at 0, memory type 2 (NOR) selects basic mode 2, which times like mode B. Types 0, 1 and 3 select basic mode 1, which times like mode A. This applies to both reads and writes.
- R3: With the bank's extended bit at 1, a read uses the bank's 2-bit read-mode field and a write uses its 2-bit write-mode field. The codes are A=0, B=1, C=2 and D=3.
- R4: Chip select stays low for exactly addset + datast consecutive clocks. Addset is 4 bits (0..15) and datast is 8 bits, with 0 treated as 1. A write in mode D adds one more clock.
- R5: During a read, `mem_we_n_o` and both byte-lane enables stay at their read values for every clock with chip select low: write enable high, lanes low. Output enable is low only during the datast data clocks, except in mode B, where it is low for the whole chip-select window.
- R6: Read data is captured on the last data-phase clock. It is presented on `rsp_data_o` with `rsp_valid_o` high for exactly one clock, in the first clock after chip select returns high.
- R7: During a write, `mem_oe_n_o` stays high and the write data is driven on the data bus for every clock with chip select low. `mem_we_n_o` goes low on the first data-phase clock. It stays low for datast clocks, except in mode C with datast of 2 or more, where it rises one clock early (datast - 1 clocks).
- R8: During a write, byte-lane enable bit i is the inverse of `req_be_i[i]`. Bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R9: The data bus is released (high impedance) whenever no write is in progress. Read data therefore arrives undisturbed.
- R10: Once chip select rises, at least one clock with every chip select high passes before the next transaction. `req_ready_o` is low in that first clock.
- R11: At most one chip select is low at a time, and it is the one indexed by the accepted `req_bank_i`.
- R12: Configuration inputs are sampled when a request is accepted. Changing them during the transaction does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | 2 | Target bank |
| req_addr_i | input | 26 | Memory address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte strobes, active high |
| rsp_valid_o | output | 1 | One-clock read response pulse |
| rsp_data_o | output | 16 | Captured read data |
| cfg_mtype_i | input | 8 | Memory type per bank, 2 bits each |
| cfg_ext_i | input | 4 | Extended-mode enable per bank |
| cfg_rd_mode_i | input | 8 | Read timing mode per bank, 2 bits each |
| cfg_wr_mode_i | input | 8 | Write timing mode per bank, 2 bits each |
| cfg_addset_i | input | 16 | Address-setup clocks per bank, 4 bits each |
| cfg_datast_i | input | 32 | Data-phase clocks per bank, 8 bits each |
| mem_addr_o | output | 26 | Memory address |
| mem_data_io | inout | 16 | Memory data bus |
| mem_cs_n_o | output | 4 | Chip select per bank, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_ble_n_o | output | 2 | Byte-lane enables, active low |

## Verification
The assertions check on every cycle the properties that hold whatever the configuration:
- chip selects are one-hot or idle;
- output enable and write enable are never low together;
- read lane values hold while output enable is low;
- the bus is released while chip select is high;
- the response pulse lasts one clock and falls in a chip-select-high cycle;
- the controller is not ready in the clock right after chip select rises.

Only the bench's scenarios can show that the phase lengths, the strobe start positions and the mode chosen from type, extended bit and direction match the configuration. They also show that read data equals what the memory presented, that lanes follow the strobes, and that configuration changed mid-cycle has no effect.

// File: rtl/asmc_pkg.sv
package asmc_pkg;
  localparam int AS_W = 4;
  localparam int DS_W = 8;

  typedef enum logic [1:0] {
    MODE_A = 2'd0,
    MODE_B = 2'd1,
    MODE_C = 2'd2,
    MODE_D = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_DATA  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_GAP   = 3'd4
  } state_e;

  localparam logic [1:0] MTYPE_NOR = 2'd2;

  // basic mode 1 times as A, basic mode 2 (NOR) as B
  function automatic mode_e pick_mode(input logic ext, input logic [1:0] mtype,
                                      input logic [1:0] rd_m, input logic [1:0] wr_m,
                                      input logic wr);
    if (ext) return mode_e'(wr ? wr_m : rd_m);
    return (mtype == MTYPE_NOR) ? MODE_B : MODE_A;
  endfunction
endpackage

// File: rtl/asmc_cfg_sel.sv
module asmc_cfg_sel
  import asmc_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input  logic [BANK_W-1:0]     bank_i,
  input  logic                  wr_i,
  input  logic [2*NBANK-1:0]    cfg_mtype_i,
  input  logic [NBANK-1:0]      cfg_ext_i,
  input  logic [2*NBANK-1:0]    cfg_rd_mode_i,
  input  logic [2*NBANK-1:0]    cfg_wr_mode_i,
  input  logic [AS_W*NBANK-1:0] cfg_addset_i,
  input  logic [DS_W*NBANK-1:0] cfg_datast_i,
  output mode_e                 mode_o,
  output logic [AS_W-1:0]       addset_o,
  output logic [DS_W-1:0]       datast_o
);
  logic [1:0]      mtype_a [NBANK];
  logic [1:0]      rdm_a   [NBANK];
  logic [1:0]      wrm_a   [NBANK];
  logic [AS_W-1:0] as_a    [NBANK];
  logic [DS_W-1:0] ds_a    [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_unpack
    assign mtype_a[g] = cfg_mtype_i[2*g +: 2];
    assign rdm_a[g]   = cfg_rd_mode_i[2*g +: 2];
    assign wrm_a[g]   = cfg_wr_mode_i[2*g +: 2];
    assign as_a[g]    = cfg_addset_i[AS_W*g +: AS_W];
    assign ds_a[g]    = cfg_datast_i[DS_W*g +: DS_W];
  end

  always_comb begin
    mode_o   = pick_mode(cfg_ext_i[bank_i], mtype_a[bank_i], rdm_a[bank_i],
                         wrm_a[bank_i], wr_i);
    addset_o = as_a[bank_i];
    datast_o = (ds_a[bank_i] == '0) ? DS_W'(1) : ds_a[bank_i];
  end
endmodule

// File: rtl/asmc_seq.sv
module asmc_seq
  import asmc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  mode_e             mode_i,
  input  logic [AS_W-1:0]   addset_i,
  input  logic [DS_W-1:0]   datast_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output state_e            state_o,
  output mode_e             mode_o,
  output logic              wr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BE_W-1:0]   be_o,
  output logic              early_rel_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  state_e            state_q;
  mode_e             mode_q;
  logic [DS_W-1:0]   cnt_q;
  logic [DS_W-1:0]   datast_q;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_A;
      cnt_q       <= '0;
      datast_q    <= DS_W'(1);
      wr_q        <= 1'b0;
      bank_q      <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          mode_q   <= mode_i;
          datast_q <= datast_i;
          wr_q     <= req_we_i;
          bank_q   <= req_bank_i;
          addr_q   <= req_addr_i;
          wdata_q  <= req_wdata_i;
          be_q     <= req_be_i;
          if (addset_i != '0) begin
            state_q <= ST_SETUP;
            cnt_q   <= DS_W'(addset_i) - DS_W'(1);
          end else begin
            state_q <= ST_DATA;
            cnt_q   <= datast_i - DS_W'(1);
          end
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= ST_DATA;
            cnt_q   <= datast_q - DS_W'(1);
          end else begin
            cnt_q <= cnt_q - DS_W'(1);
          end
        end
        ST_DATA: begin
          if (cnt_q == '0) begin
            // sample while chip select is still low
            if (!wr_q) begin
              rsp_data_q  <= mem_rdata_i;
              rsp_valid_q <= 1'b1;
            end
            state_q <= (wr_q && mode_q == MODE_D) ? ST_HOLD : ST_GAP;
          end else begin
            cnt_q <= cnt_q - DS_W'(1);
          end
        end
        ST_HOLD: state_q <= ST_GAP;
        ST_GAP:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign state_o     = state_q;
  assign mode_o      = mode_q;
  assign wr_o        = wr_q;
  assign bank_o      = bank_q;
  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;
  assign be_o        = be_q;
  assign early_rel_o = (state_q == ST_DATA) && (cnt_q == '0) && (datast_q > DS_W'(1));
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R1
  AST_SETUP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP) |-> (cnt_q < DS_W'(16))); // R4
  AST_RSP_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R6
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> $stable(addr_o)); // R12
endmodule

// File: rtl/asmc_pins.sv
module asmc_pins
  import asmc_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int BE_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_i,
  input  mode_e             mode_i,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              early_rel_i,
  output logic [NBANK-1:0]  cs_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [BE_W-1:0]   ble_n_o,
  output logic              drv_en_o
);
  logic active;
  assign active = (state_i == ST_SETUP) || (state_i == ST_DATA) || (state_i == ST_HOLD);

  for (genvar g = 0; g < NBANK; g++) begin : g_cs
    assign cs_n_o[g] = !(active && (bank_i == BANK_W'(g)));
  end

  assign oe_n_o   = !(!wr_i && ((state_i == ST_DATA) ||
                                (mode_i == MODE_B && state_i == ST_SETUP)));
  assign we_n_o   = !(wr_i && (state_i == ST_DATA) && !(mode_i == MODE_C && early_rel_i));
  assign ble_n_o  = !active ? '1 : (wr_i ? ~be_i : '0);
  assign drv_en_o = active && wr_i;

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o)); // R11
  AST_OE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n_o && !we_n_o)); // R5
  AST_READ_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> (ble_n_o == '0 && we_n_o && !drv_en_o)); // R5
  AST_BUS_FREE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_n_o) |-> !drv_en_o); // R9
endmodule

// File: rtl/asmc_top.sv
module asmc_top
  import asmc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int NBANK  = 4,
  localparam int BE_W   = DATA_W / 8,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_we_i,
  input  logic [BANK_W-1:0]     req_bank_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  input  logic [BE_W-1:0]       req_be_i,
  output logic                  rsp_valid_o,
  output logic [DATA_W-1:0]     rsp_data_o,
  input  logic [2*NBANK-1:0]    cfg_mtype_i,
  input  logic [NBANK-1:0]      cfg_ext_i,
  input  logic [2*NBANK-1:0]    cfg_rd_mode_i,
  input  logic [2*NBANK-1:0]    cfg_wr_mode_i,
  input  logic [AS_W*NBANK-1:0] cfg_addset_i,
  input  logic [DS_W*NBANK-1:0] cfg_datast_i,
  output logic [ADDR_W-1:0]     mem_addr_o,
  inout  wire  [DATA_W-1:0]     mem_data_io,
  output logic [NBANK-1:0]      mem_cs_n_o,
  output logic                  mem_oe_n_o,
  output logic                  mem_we_n_o,
  output logic [BE_W-1:0]       mem_ble_n_o
);
  mode_e             sel_mode, cur_mode;
  logic [AS_W-1:0]   sel_as;
  logic [DS_W-1:0]   sel_ds;
  state_e            state;
  logic              cur_wr, early_rel, drv_en;
  logic [BANK_W-1:0] cur_bank;
  logic [DATA_W-1:0] cur_wdata;
  logic [BE_W-1:0]   cur_be;

  asmc_cfg_sel #(.NBANK(NBANK), .BANK_W(BANK_W)) u_cfg (
    .bank_i(req_bank_i), .wr_i(req_we_i),
    .cfg_mtype_i(cfg_mtype_i), .cfg_ext_i(cfg_ext_i),
    .cfg_rd_mode_i(cfg_rd_mode_i), .cfg_wr_mode_i(cfg_wr_mode_i),
    .cfg_addset_i(cfg_addset_i), .cfg_datast_i(cfg_datast_i),
    .mode_o(sel_mode), .addset_o(sel_as), .datast_o(sel_ds)
  );

  asmc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .BANK_W(BANK_W)) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_we_i, .req_bank_i, .req_addr_i,
    .req_wdata_i, .req_be_i,
    .mode_i(sel_mode), .addset_i(sel_as), .datast_i(sel_ds),
    .mem_rdata_i(mem_data_io),
    .state_o(state), .mode_o(cur_mode), .wr_o(cur_wr), .bank_o(cur_bank),
    .addr_o(mem_addr_o), .wdata_o(cur_wdata), .be_o(cur_be),
    .early_rel_o(early_rel), .rsp_valid_o, .rsp_data_o
  );

  asmc_pins #(.NBANK(NBANK), .BANK_W(BANK_W), .BE_W(BE_W)) u_pins (
    .clk_i, .rst_ni,
    .state_i(state), .mode_i(cur_mode), .wr_i(cur_wr), .bank_i(cur_bank),
    .be_i(cur_be), .early_rel_i(early_rel),
    .cs_n_o(mem_cs_n_o), .oe_n_o(mem_oe_n_o), .we_n_o(mem_we_n_o),
    .ble_n_o(mem_ble_n_o), .drv_en_o(drv_en)
  );

  assign mem_data_io = drv_en ? cur_wdata : {DATA_W{1'bz}};

  AST_RSP_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (&mem_cs_n_o)); // R6
  AST_GAP_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(&mem_cs_n_o) |-> !req_ready_o); // R10
endmodule

// File: tb/tb_asmc_top.sv
`timescale 1ns/1ps
module tb_asmc_top;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [1:0]  req_bank = '0, req_be = '0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [25:0] mem_addr;
  logic [3:0]  cs_n;
  logic        oe_n, we_n;
  logic [1:0]  ble_n;
  wire  [15:0] mem_bus;

  logic [1:0] c_mt [NB], c_rd [NB], c_wr [NB];
  logic       c_ext [NB];
  logic [3:0] c_as [NB];
  logic [7:0] c_ds [NB];
  logic [7:0]  p_mt, p_rd, p_wr;
  logic [3:0]  p_ext;
  logic [15:0] p_as;
  logic [31:0] p_ds;
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      p_mt[2*i +: 2] = c_mt[i]; p_rd[2*i +: 2] = c_rd[i]; p_wr[2*i +: 2] = c_wr[i];
      p_ext[i] = c_ext[i]; p_as[4*i +: 4] = c_as[i]; p_ds[8*i +: 8] = c_ds[i];
    end
  end

  function automatic logic [15:0] model_f(input logic [25:0] a);
    return a[15:0] ^ 16'hA5C3 ^ {a[25:16], 6'b0};
  endfunction
  assign mem_bus = (!oe_n && !(&cs_n)) ? model_f(mem_addr) : 16'hzzzz;

  asmc_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_bank_i(req_bank), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_be_i(req_be), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .cfg_mtype_i(p_mt), .cfg_ext_i(p_ext), .cfg_rd_mode_i(p_rd),
    .cfg_wr_mode_i(p_wr), .cfg_addset_i(p_as), .cfg_datast_i(p_ds),
    .mem_addr_o(mem_addr), .mem_data_io(mem_bus), .mem_cs_n_o(cs_n),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_ble_n_o(ble_n)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // expectations for the running transaction
  logic [15:0] exp_q[$];
  int   e_bank;
  bit   e_wr;
  logic [1:0]  e_be;
  logic [15:0] e_wd;

  // monitor measurements
  int  m_cs, m_oe, m_we, m_oe_first, m_we_first;
  bit  m_ble_bad, m_bank_bad, m_data_bad;
  int  done_cnt = 0;
  bit  prev_act = 1'b0, rv_low_next = 1'b0;

  always @(negedge clk) begin
    bit act, rel;
    act = !(&cs_n);
    rel = prev_act && !act;
    if (rst_n) begin
      if (act) begin
        if (!prev_act) begin
          m_cs = 0; m_oe = 0; m_we = 0; m_oe_first = -1; m_we_first = -1;
          m_ble_bad = 0; m_bank_bad = 0; m_data_bad = 0;
        end
        if (!oe_n) begin if (m_oe_first < 0) m_oe_first = m_cs; m_oe++; end
        if (!we_n) begin if (m_we_first < 0) m_we_first = m_cs; m_we++; end
        if (ble_n !== (e_wr ? ~e_be : 2'b00)) m_ble_bad = 1;
        if (cs_n !== ~(4'b1 << e_bank)) m_bank_bad = 1;
        if (e_wr && mem_bus !== e_wd) m_data_bad = 1;
        if (!e_wr && !we_n) m_ble_bad = 1;
        m_cs++;
      end
      if (rv_low_next) begin
        chk(rsp_valid == 1'b0, "R6", "response longer than one clock", rsp_valid, 0);
        rv_low_next = 0;
      end
      if (rel) begin
        chk(rsp_valid == !e_wr, "R6", "response in first clock after release", rsp_valid, !e_wr);
        chk(req_ready == 1'b0, "R10", "ready in gap clock", req_ready, 0);
        rv_low_next = 1;
        done_cnt++;
      end else if (rsp_valid) begin
        chk(0, "R6", "response outside release clock", 1, 0);
      end
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(0, "R6", "unexpected read response", rsp_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rsp_data == e, "R6", "read data (R9 bus free)", rsp_data, e);
        end
      end
    end
    prev_act = act;
  end

  function automatic int mode_of(input int b, input bit wr);
    if (c_ext[b]) return int'(wr ? c_wr[b] : c_rd[b]);
    return (c_mt[b] == 2'd2) ? 1 : 0;
  endfunction

  task automatic run(input int b, input bit wr, input logic [25:0] a,
                     input logic [15:0] d, input logic [1:0] be,
                     input bit scramble, input string rq);
    int as, ds, md, e_cs, e_oe, e_we, e_oef, e_wef, start;
    logic [3:0] s_as; logic [7:0] s_ds; logic s_ext;
    as = int'(c_as[b]);
    ds = (c_ds[b] == 0) ? 1 : int'(c_ds[b]);
    md = mode_of(b, wr);
    e_cs = as + ds + ((wr && md == 3) ? 1 : 0);
    e_oe = wr ? 0 : ((md == 1) ? as + ds : ds);
    e_oef = wr ? -1 : ((md == 1) ? 0 : as);
    e_we = !wr ? 0 : ((md == 2 && ds > 1) ? ds - 1 : ds);
    e_wef = wr ? as : -1;
    e_bank = b; e_wr = wr; e_be = be; e_wd = d;
    if (!wr) exp_q.push_back(model_f(a));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = wr; req_bank = 2'(b); req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
    s_as = c_as[b]; s_ds = c_ds[b]; s_ext = c_ext[b];
    if (scramble) begin c_as[b] = 4'd0; c_ds[b] = 8'd1; c_ext[b] = ~c_ext[b]; end
    start = done_cnt;
    while (done_cnt == start) @(negedge clk);
    chk(m_cs == e_cs, {"R4 ", rq}, "chip select length", m_cs, e_cs);
    chk(m_oe == e_oe && m_oe_first == e_oef, wr ? {"R7 ", rq} : {"R5 ", rq},
        "output enable length/start", {m_oe, m_oe_first}, {e_oe, e_oef});
    chk(m_we == e_we && m_we_first == e_wef, wr ? {"R7 ", rq} : {"R5 ", rq},
        "write enable length/start", {m_we, m_we_first}, {e_we, e_wef});
    chk(!m_ble_bad, wr ? "R8" : "R5", "byte lanes / write enable during cycle", m_ble_bad, 0);
    chk(!m_bank_bad, "R11", "chip select bank", m_bank_bad, 0);
    if (wr) chk(!m_data_bad, "R7", "write data on bus", m_data_bad, 0);
    if (scramble) begin c_as[b] = s_as; c_ds[b] = s_ds; c_ext[b] = s_ext; end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    chk(0, "R1", "watchdog expired", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      c_mt[i] = 0; c_rd[i] = 0; c_wr[i] = 0; c_ext[i] = 0; c_as[i] = 1; c_ds[i] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0, "R1", "reset ready/valid", {req_ready, rsp_valid}, 2'b10);
    chk(cs_n == 4'hF && oe_n && we_n && ble_n == 2'b11, "R1", "reset pins",
        {cs_n, oe_n, we_n, ble_n}, 8'hFF);

    // basic mode 1 (SRAM type 0)
    c_mt[0] = 0; c_as[0] = 2; c_ds[0] = 3;
    run(0, 0, 26'h0001234, 16'h0, 2'b00, 0, "R2");
    run(0, 1, 26'h0001236, 16'hBEEF, 2'b11, 0, "R2");
    // basic mode 2 (NOR)
    c_mt[1] = 2; c_as[1] = 3; c_ds[1] = 2;
    run(1, 0, 26'h2ABCDE0, 16'h0, 2'b00, 0, "R2");
    run(1, 1, 26'h2ABCDE2, 16'h1234, 2'b01, 0, "R2");
    // type 3, zero setup, zero datast -> one clock
    c_mt[2] = 3; c_as[2] = 0; c_ds[2] = 0;
    run(2, 0, 26'h0000042, 16'h0, 2'b00, 0, "R2");
    // pseudo-static type 1
    c_mt[0] = 1;
    run(0, 0, 26'h3FFFFFF, 16'h0, 2'b00, 0, "R2");
    // extended: read C, write D
    c_ext[3] = 1; c_rd[3] = 2; c_wr[3] = 3; c_as[3] = 1; c_ds[3] = 4;
    run(3, 0, 26'h0100000, 16'h0, 2'b00, 0, "R3");
    run(3, 1, 26'h0100002, 16'hA55A, 2'b11, 0, "R3");
    // extended: read B, write C, upper lane only
    c_rd[3] = 1; c_wr[3] = 2;
    run(3, 0, 26'h0100004, 16'h0, 2'b00, 0, "R3");
    run(3, 1, 26'h0100006, 16'h5AA5, 2'b10, 0, "R3");
    // mode C with datast 1: no early release
    c_ds[3] = 1;
    run(3, 1, 26'h0100008, 16'h0F0F, 2'b01, 0, "R3");
    // extended read A, write D, zero setup
    c_rd[3] = 0; c_wr[3] = 3; c_as[3] = 0; c_ds[3] = 2;
    run(3, 0, 26'h010000A, 16'h0, 2'b00, 0, "R3");
    run(3, 1, 26'h010000C, 16'hC3C3, 2'b00, 0, "R3");
    // longest: setup 15, datast 255, write mode C
    c_ext[2] = 1; c_wr[2] = 2; c_as[2] = 15; c_ds[2] = 255;
    run(2, 1, 26'h0FEDCBA, 16'h7E7E, 2'b11, 0, "R4");
    c_rd[2] = 1;
    run(2, 0, 26'h0FEDCBC, 16'h0, 2'b00, 0, "R4");
    // configuration changed after accept
    c_as[0] = 4; c_ds[0] = 6;
    run(0, 0, 26'h0002000, 16'h0, 2'b00, 1, "R12");
    run(0, 1, 26'h0002002, 16'h3C3C, 2'b11, 1, "R12");
    // back-to-back on different banks
    run(1, 0, 26'h0003000, 16'h0, 2'b00, 0, "R10");
    run(0, 0, 26'h0003002, 16'h0, 2'b00, 0, "R10");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "responses outstanding", exp_q.size(), 0);
    chk(cs_n == 4'hF && req_ready == 1, "R1", "idle at end", {cs_n, req_ready}, 5'h1F);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule